// File: doc/BRIEF.md
# ADC reset and offset-calibration sequencer

This block steers the digital back end of a two-channel audio ADC from power-up to normal conversion. The active-low power-down pin holds the control registers in reset and mutes the data path. When the pin is released, the block first blocks every register write for a short start-up phase. It then runs a calibration window of fixed length, counted in sample-rate ticks.

During calibration both channel outputs are held at two's-complement zero. Writes to the calibration-sensitive register address are refused there, while writes to the other addresses go through. The tail of the window is averaged to give a DC offset for each channel. In normal running each output word is the input sample minus that offset, clamped to the signed sample range. The PGA mute flag is raised for calibration and stays raised until software clears it.

Either power-management bit going low zeroes the outputs at once. When both bits come back, normal running resumes with the stored offsets and no new calibration.

Top module: `adc_cal_seq`

## Requirements
- R1: While `pdn_n` is low, `regs_rst` and `force_zero` are 1, both outputs are 0, `pga_mute` is 1 and every bit of `wr_gate` is 0.
- R2: After `pdn_n` rises, a start-up phase lasts 4 `fs_tick` pulses, during which `wr_gate` is all zero and `cal_busy` is 0.
- R3: `cal_busy` is 1 for exactly 4128 `fs_tick` pulses following the start-up phase, then returns to 0.
- R4: Both output words are 0 during power-down, start-up and calibration.
- R5: `pga_mute` is 1 when calibration begins and stays 1 after it ends. A write to address 2 sets `pga_mute` to data bit 0, and such a write is accepted during calibration as well as afterwards.
- R6: During calibration `wr_gate[1]` is 0 and all other gate bits are 1. In normal and power-management states every gate bit is 1.
- R7: Each channel's offset is the sum of the final 4096 samples of the calibration window shifted right arithmetically by 12 (floor of the mean).
- R8: In normal running, on each `fs_tick` the output becomes the sample minus the offset, saturated to [-8388608, 8388607]. It is visible after that clock edge.
- R9: When `pm0` or `pm1` is 0, both outputs are 0 from the next clock edge. When both return to 1, corrected output resumes with the same offsets and `cal_busy` stays 0.
- R10: `force_zero` is 1 whenever the outputs are being forced to zero, and 0 in normal running with both power-management bits at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| pdn_n | input | 1 | Active-low power-down pin, sampled on `clk` |
| fs_tick | input | 1 | One-cycle pulse per sample period |
| pm0 | input | 1 | Power-management bit 0 (1 = powered) |
| pm1 | input | 1 | Power-management bit 1 (1 = powered) |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 8 | Register write data |
| wr_stb | input | 1 | Register write strobe |
| smp_l | input | 24 | Left-channel raw sample, taken on `fs_tick` |
| smp_r | input | 24 | Right-channel raw sample, taken on `fs_tick` |
| regs_rst | output | 1 | Reset to the control register bank |
| cal_busy | output | 1 | Calibration window active |
| pga_mute | output | 1 | PGA mute request |
| wr_gate | output | 8 | Per-address write enable |
| force_zero | output | 1 | Serial data forced to zero |
| out_l | output | 24 | Corrected left-channel word |
| out_r | output | 24 | Corrected right-channel word |

## Verification
A miscounting sequencer shows up at `cal_busy` as a window that is one or more ticks too long or too short. It also shows up in the first corrected word, which comes out either zero or early by a sample.

A wrong accumulator window or a wrong shift is not visible during calibration, because the outputs are zero then. It appears on the first normal tick as a constant error in every word of that channel. The saturation cases expose an offset with the wrong sign.

A state that fails to gate the locked address, or fails to keep the mute raised, is visible at `wr_gate` and `pga_mute` within the same cycle.

// File: rtl/adc_cal_pkg.sv
package adc_cal_pkg;

  typedef enum logic [2:0] {
    ST_PD     = 3'd0,
    ST_INIT   = 3'd1,
    ST_CAL    = 3'd2,
    ST_NORMAL = 3'd3,
    ST_PM     = 3'd4
  } seq_state_t;

endpackage

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
  import adc_cal_pkg::*;
#(
  parameter int CAL_TICKS  = 4128,
  parameter int INIT_TICKS = 4,
  parameter int AVG_LOG2   = 12
) (
  input  logic       clk,
  input  logic       pdn_n,
  input  logic       fs_tick,
  input  logic       pm_ok,
  output seq_state_t state,
  output logic       init_done,
  output logic       cal_done,
  output logic       acc_clr,
  output logic       acc_en
);

  localparam int MAX_CNT = (CAL_TICKS > INIT_TICKS) ? CAL_TICKS : INIT_TICKS;
  localparam int CNT_W   = $clog2(MAX_CNT);
  localparam logic [CNT_W-1:0] INIT_LAST = CNT_W'(INIT_TICKS - 1);
  localparam logic [CNT_W-1:0] CAL_LAST  = CNT_W'(CAL_TICKS - 1);
  localparam logic [CNT_W-1:0] WIN_START = CNT_W'(CAL_TICKS - (1 << AVG_LOG2));

  seq_state_t       nxt;
  logic [CNT_W-1:0] cnt;

  // phase events, brought out for the checker and the datapath
  assign init_done = (state == ST_INIT) && fs_tick && (cnt == INIT_LAST);
  assign cal_done  = (state == ST_CAL)  && fs_tick && (cnt == CAL_LAST);
  assign acc_clr   = (state == ST_INIT);
  assign acc_en    = (state == ST_CAL)  && (cnt >= WIN_START);

  always_comb begin
    nxt = state;
    case (state)
      ST_PD:     nxt = ST_INIT;
      ST_INIT:   if (init_done) nxt = ST_CAL;
      ST_CAL:    if (cal_done)  nxt = ST_NORMAL;
      ST_NORMAL: if (!pm_ok)    nxt = ST_PM;
      ST_PM:     if (pm_ok)     nxt = ST_NORMAL;
      default:   nxt = ST_PD;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!pdn_n) begin
      state <= ST_PD;
      cnt   <= '0;
    end else begin
      state <= nxt;
      if (nxt != state)
        cnt <= '0;
      else if (fs_tick && (state == ST_INIT || state == ST_CAL))
        cnt <= cnt + 1'b1;
    end
  end

endmodule

// File: rtl/adc_offset_chan.sv
module adc_offset_chan #(
  parameter int SMP_W    = 24,
  parameter int AVG_LOG2 = 12
) (
  input  logic             clk,
  input  logic             pdn_n,
  input  logic             smp_tick,
  input  logic             acc_clr,
  input  logic             acc_en,
  input  logic             cal_store,
  input  logic             zero_out,
  input  logic [SMP_W-1:0] smp_in,
  output logic [SMP_W-1:0] out_word
);

  localparam int ACC_W = SMP_W + AVG_LOG2 + 1;

  function automatic logic signed [ACC_W-1:0] widen(input logic [SMP_W-1:0] v);
    widen = {{(ACC_W-SMP_W){v[SMP_W-1]}}, v};
  endfunction

  function automatic logic [SMP_W-1:0] mean_of(input logic signed [ACC_W-1:0] s);
    logic signed [ACC_W-1:0] q;
    q = s >>> AVG_LOG2;
    mean_of = q[SMP_W-1:0];
  endfunction

  function automatic logic [SMP_W-1:0] sat_sub(input logic [SMP_W-1:0] a,
                                               input logic [SMP_W-1:0] b);
    logic [SMP_W:0] d;
    d = {a[SMP_W-1], a} - {b[SMP_W-1], b};
    if (d[SMP_W] != d[SMP_W-1])
      sat_sub = d[SMP_W] ? {1'b1, {(SMP_W-1){1'b0}}} : {1'b0, {(SMP_W-1){1'b1}}};
    else
      sat_sub = d[SMP_W-1:0];
  endfunction

  logic signed [ACC_W-1:0] acc;
  logic signed [ACC_W-1:0] acc_sum;
  logic [SMP_W-1:0]        offset;

  assign acc_sum = acc + widen(smp_in);

  always_ff @(posedge clk) begin
    if (!pdn_n) begin
      acc    <= '0;
      offset <= '0;
    end else begin
      if (acc_clr)
        acc <= '0;
      else if (smp_tick && acc_en)
        acc <= acc_sum;
      if (smp_tick && cal_store)
        offset <= mean_of(acc_sum);
    end
  end

  always_ff @(posedge clk) begin
    if (!pdn_n || zero_out)
      out_word <= '0;
    else if (smp_tick)
      out_word <= sat_sub(smp_in, offset);
  end

endmodule

// File: rtl/adc_wr_ctl.sv
module adc_wr_ctl
  import adc_cal_pkg::*;
#(
  parameter int ADDR_W    = 3,
  parameter int DATA_W    = 8,
  parameter int LOCK_ADDR = 1,
  parameter int MUTE_ADDR = 2,
  parameter int MUTE_BIT  = 0
) (
  input  logic                   clk,
  input  logic                   pdn_n,
  input  seq_state_t             state,
  input  logic [ADDR_W-1:0]      wr_addr,
  input  logic [DATA_W-1:0]      wr_data,
  input  logic                   wr_stb,
  output logic [(1<<ADDR_W)-1:0] wr_gate,
  output logic                   pga_mute
);

  localparam int NUM_ADDR = 1 << ADDR_W;

  logic open_all;
  logic open_most;
  logic wr_take;

  assign open_all  = (state == ST_NORMAL) || (state == ST_PM);
  assign open_most = (state == ST_CAL);

  for (genvar a = 0; a < NUM_ADDR; a++) begin : g_gate
    if (a == LOCK_ADDR) begin : g_lock
      assign wr_gate[a] = open_all;
    end else begin : g_free
      assign wr_gate[a] = open_all || open_most;
    end
  end

  assign wr_take = wr_stb && wr_gate[wr_addr];

  always_ff @(posedge clk) begin
    if (!pdn_n)
      pga_mute <= 1'b1;
    else if (state == ST_INIT)
      pga_mute <= 1'b1;
    else if (wr_take && wr_addr == ADDR_W'(MUTE_ADDR))
      pga_mute <= wr_data[MUTE_BIT];
  end

endmodule

// File: rtl/adc_cal_seq.sv
module adc_cal_seq
  import adc_cal_pkg::*;
#(
  parameter int SMP_W      = 24,
  parameter int ADDR_W     = 3,
  parameter int DATA_W     = 8,
  parameter int CAL_TICKS  = 4128,
  parameter int INIT_TICKS = 4,
  parameter int AVG_LOG2   = 12,
  parameter int LOCK_ADDR  = 1,
  parameter int MUTE_ADDR  = 2,
  parameter int MUTE_BIT   = 0
) (
  input  logic                   clk,
  input  logic                   pdn_n,
  input  logic                   fs_tick,
  input  logic                   pm0,
  input  logic                   pm1,
  input  logic [ADDR_W-1:0]      wr_addr,
  input  logic [DATA_W-1:0]      wr_data,
  input  logic                   wr_stb,
  input  logic [SMP_W-1:0]       smp_l,
  input  logic [SMP_W-1:0]       smp_r,
  output logic                   regs_rst,
  output logic                   cal_busy,
  output logic                   pga_mute,
  output logic [(1<<ADDR_W)-1:0] wr_gate,
  output logic                   force_zero,
  output logic [SMP_W-1:0]       out_l,
  output logic [SMP_W-1:0]       out_r
);

  localparam int NUM_CH = 2;

  seq_state_t       state;
  logic             pm_ok;
  logic             zero_out;
  logic             init_done;
  logic             cal_done;
  logic             acc_clr;
  logic             acc_en;
  logic [SMP_W-1:0] smp_a [NUM_CH];
  logic [SMP_W-1:0] out_a [NUM_CH];

  assign pm_ok      = pm0 && pm1;
  assign zero_out   = (state != ST_NORMAL) || !pm_ok;
  assign regs_rst   = !pdn_n || (state == ST_PD);
  assign cal_busy   = (state == ST_CAL);
  assign force_zero = zero_out || !pdn_n;

  adc_seq_fsm #(
    .CAL_TICKS (CAL_TICKS),
    .INIT_TICKS(INIT_TICKS),
    .AVG_LOG2  (AVG_LOG2)
  ) u_fsm (
    .clk      (clk),
    .pdn_n    (pdn_n),
    .fs_tick  (fs_tick),
    .pm_ok    (pm_ok),
    .state    (state),
    .init_done(init_done),
    .cal_done (cal_done),
    .acc_clr  (acc_clr),
    .acc_en   (acc_en)
  );

  adc_wr_ctl #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .LOCK_ADDR(LOCK_ADDR),
    .MUTE_ADDR(MUTE_ADDR),
    .MUTE_BIT (MUTE_BIT)
  ) u_wr (
    .clk     (clk),
    .pdn_n   (pdn_n),
    .state   (state),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .wr_stb  (wr_stb),
    .wr_gate (wr_gate),
    .pga_mute(pga_mute)
  );

  assign smp_a[0] = smp_l;
  assign smp_a[1] = smp_r;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
    adc_offset_chan #(
      .SMP_W   (SMP_W),
      .AVG_LOG2(AVG_LOG2)
    ) u_chan (
      .clk      (clk),
      .pdn_n    (pdn_n),
      .smp_tick (fs_tick),
      .acc_clr  (acc_clr),
      .acc_en   (acc_en),
      .cal_store(cal_done),
      .zero_out (zero_out),
      .smp_in   (smp_a[c]),
      .out_word (out_a[c])
    );
  end

  assign out_l = out_a[0];
  assign out_r = out_a[1];

endmodule

// File: rtl/adc_cal_seq_chk.sv
module adc_cal_seq_chk #(
  parameter int SMP_W     = 24,
  parameter int NUM_ADDR  = 8,
  parameter int CAL_TICKS = 4128,
  parameter int LOCK_ADDR = 1
) (
  input logic                clk,
  input logic                pdn_n,
  input logic                fs_tick,
  input logic                pm0,
  input logic                pm1,
  input logic                cal_busy,
  input logic                pga_mute,
  input logic [NUM_ADDR-1:0] wr_gate,
  input logic [SMP_W-1:0]    out_l,
  input logic [SMP_W-1:0]    out_r
);

  logic [31:0] cal_seen;

  always_ff @(posedge clk) begin
    if (!pdn_n || !cal_busy)
      cal_seen <= '0;
    else if (fs_tick)
      cal_seen <= cal_seen + 32'd1;
  end

  a_r2_init_closed: assert property (@(posedge clk) disable iff (!pdn_n)
    $rose(cal_busy) |-> ($past(wr_gate) == '0));

  a_r3_cal_len: assert property (@(posedge clk) disable iff (!pdn_n)
    $fell(cal_busy) |-> (cal_seen == 32'(CAL_TICKS)));

  a_r4_cal_zero: assert property (@(posedge clk) disable iff (!pdn_n)
    cal_busy |-> (out_l == '0 && out_r == '0));

  a_r5_mute_at_cal: assert property (@(posedge clk) disable iff (!pdn_n)
    $rose(cal_busy) |-> pga_mute);

  a_r6_lock_blocked: assert property (@(posedge clk) disable iff (!pdn_n)
    cal_busy |-> !wr_gate[LOCK_ADDR]);

  a_r9_pm_zero: assert property (@(posedge clk) disable iff (!pdn_n)
    (!pm0 || !pm1) |=> (out_l == '0 && out_r == '0));

endmodule

bind adc_cal_seq adc_cal_seq_chk #(
  .SMP_W    (SMP_W),
  .NUM_ADDR (1 << ADDR_W),
  .CAL_TICKS(CAL_TICKS),
  .LOCK_ADDR(LOCK_ADDR)
) u_chk (
  .clk     (clk),
  .pdn_n   (pdn_n),
  .fs_tick (fs_tick),
  .pm0     (pm0),
  .pm1     (pm1),
  .cal_busy(cal_busy),
  .pga_mute(pga_mute),
  .wr_gate (wr_gate),
  .out_l   (out_l),
  .out_r   (out_r)
);

// File: tb/sim_adc_cal_seq.sv
module sim_adc_cal_seq;

  localparam int CLK_NS = 10;
  localparam int SW     = 24;
  localparam int NA     = 8;
  localparam longint SMAX = 8388607;
  localparam longint SMIN = -8388608;

  logic          clk = 1'b0;
  logic          pdn_n = 1'b0;
  logic          fs_tick = 1'b0;
  logic          pm0 = 1'b1;
  logic          pm1 = 1'b1;
  logic [2:0]    wr_addr = '0;
  logic [7:0]    wr_data = '0;
  logic          wr_stb = 1'b0;
  logic [SW-1:0] smp_l = '0;
  logic [SW-1:0] smp_r = '0;
  logic          regs_rst, cal_busy, pga_mute, force_zero;
  logic [NA-1:0] wr_gate;
  logic [SW-1:0] out_l, out_r;

  always #(CLK_NS/2) clk = ~clk;

  adc_cal_seq u0 (
    .clk(clk), .pdn_n(pdn_n), .fs_tick(fs_tick), .pm0(pm0), .pm1(pm1),
    .wr_addr(wr_addr), .wr_data(wr_data), .wr_stb(wr_stb),
    .smp_l(smp_l), .smp_r(smp_r),
    .regs_rst(regs_rst), .cal_busy(cal_busy), .pga_mute(pga_mute),
    .wr_gate(wr_gate), .force_zero(force_zero), .out_l(out_l), .out_r(out_r)
  );

  typedef struct {
    longint l;
    longint r;
    string  tag;
  } exp_t;

  exp_t   q[$];
  int     n_chk = 0;
  int     n_bad = 0;
  longint sum_l, sum_r, off_l, off_r, v_l, v_r;
  int     drop_at;

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic longint sx(input logic [SW-1:0] v);
    sx = longint'($signed(v));
  endfunction

  // floor(s / 4096) computed by division and a remainder fix-up
  function automatic longint floor_mean(input longint s);
    longint qt;
    qt = s / 4096;
    if ((s % 4096) != 0 && s < 0) qt = qt - 1;
    floor_mean = qt;
  endfunction

  function automatic longint clamp_sub(input longint a, input longint b);
    longint d;
    d = a - b;
    if (d > SMAX) d = SMAX;
    if (d < SMIN) d = SMIN;
    clamp_sub = d;
  endfunction

  // monitor: one expected item per issued sample tick
  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      chk(sx(out_l) == e.l, e.tag, "left word", sx(out_l), e.l);
      chk(sx(out_r) == e.r, e.tag, "right word", sx(out_r), e.r);
    end
  end

  task automatic do_tick(input longint l, input longint r,
                         input longint el, input longint er, input string tag);
    @(negedge clk);
    fs_tick = 1'b1;
    smp_l = SW'(l);
    smp_r = SW'(r);
    @(posedge clk);
    #1;
    fs_tick = 1'b0;
    q.push_back('{l: el, r: er, tag: tag});
  endtask

  task automatic do_write(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_addr = a;
    wr_data = d;
    wr_stb  = 1'b1;
    @(posedge clk);
    #1;
    wr_stb = 1'b0;
  endtask

  task automatic check_pd();
    @(negedge clk);
    pdn_n = 1'b0;
    @(posedge clk);
    #1;
    chk(regs_rst == 1'b1, "R1", "regs_rst", regs_rst, 1);
    chk(pga_mute == 1'b1, "R1", "pga_mute", pga_mute, 1);
    chk(wr_gate == '0, "R1", "wr_gate", wr_gate, 0);
    chk(out_l == '0 && out_r == '0, "R1", "outputs", sx(out_l), 0);
    chk(force_zero == 1'b1, "R1", "force_zero", force_zero, 1);
  endtask

  task automatic run_init();
    @(negedge clk);
    pdn_n = 1'b1;
    @(posedge clk);
    #1;
    for (int k = 0; k < 4; k++) begin
      do_tick(1234, -1234, 0, 0, "R4");
      if (k < 3) begin
        chk(cal_busy == 1'b0, "R2", "cal_busy in start-up", cal_busy, 0);
        chk(wr_gate == '0, "R2", "wr_gate in start-up", wr_gate, 0);
      end
    end
    chk(cal_busy == 1'b1, "R3", "cal_busy after start-up", cal_busy, 1);
    chk(pga_mute == 1'b1, "R5", "mute at cal start", pga_mute, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    check_pd();

    // first calibration with a polluted head and a known tail
    run_init();
    sum_l = 0;
    sum_r = 0;
    drop_at = -1;
    for (int i = 0; i < 4128; i++) begin
      if (i < 32) begin
        v_l = SMAX;
        v_r = SMIN;
      end else begin
        v_l = 990 + (i % 8) * 3;
        v_r = -5000 + (i % 16);
        sum_l += v_l;
        sum_r += v_r;
      end
      do_tick(v_l, v_r, 0, 0, "R4");
      if (!cal_busy && drop_at < 0) drop_at = i + 1;
      if (i == 100) begin
        chk(wr_gate == 8'hFD, "R6", "gate during cal", wr_gate, 8'hFD);
        chk(force_zero == 1'b1, "R10", "force_zero in cal", force_zero, 1);
      end
    end
    chk(drop_at == 4128, "R3", "cal window length", drop_at, 4128);
    off_l = floor_mean(sum_l);
    off_r = floor_mean(sum_r);
    chk(pga_mute == 1'b1, "R5", "mute after cal", pga_mute, 1);
    chk(wr_gate == 8'hFF, "R6", "gate in normal", wr_gate, 8'hFF);
    chk(force_zero == 1'b0, "R10", "force_zero in normal", force_zero, 0);

    // corrected data, including saturation both ways
    do_tick(5000, 0, clamp_sub(5000, off_l), clamp_sub(0, off_r), "R7");
    do_tick(-3000, -4993, clamp_sub(-3000, off_l), clamp_sub(-4993, off_r), "R7");
    do_tick(SMIN, SMAX, clamp_sub(SMIN, off_l), clamp_sub(SMAX, off_r), "R8");
    do_tick(SMAX, SMIN, clamp_sub(SMAX, off_l), clamp_sub(SMIN, off_r), "R8");
    do_tick(0, 0, clamp_sub(0, off_l), clamp_sub(0, off_r), "R8");

    do_write(3'd2, 8'h00);
    chk(pga_mute == 1'b0, "R5", "mute cleared by write", pga_mute, 0);

    // power-management drop and return
    @(negedge clk);
    pm0 = 1'b0;
    @(posedge clk);
    #1;
    chk(force_zero == 1'b1, "R10", "force_zero in pm", force_zero, 1);
    chk(out_l == '0 && out_r == '0, "R9", "zero after pm drop", sx(out_l), 0);
    do_tick(7000, 7000, 0, 0, "R9");
    @(negedge clk);
    pm0 = 1'b1;
    pm1 = 1'b0;
    do_tick(7000, 7000, 0, 0, "R9");
    @(negedge clk);
    pm1 = 1'b1;
    do_tick(7000, -7000, clamp_sub(7000, off_l), clamp_sub(-7000, off_r), "R9");
    chk(cal_busy == 1'b0, "R9", "no recal after pm", cal_busy, 0);
    do_tick(1, 2, clamp_sub(1, off_l), clamp_sub(2, off_r), "R9");

    // second power-down, mute cleared during calibration
    check_pd();
    run_init();
    for (int i = 0; i < 4128; i++) begin
      do_tick(0, 0, 0, 0, "R4");
      if (i == 10) begin
        chk(wr_gate[1] == 1'b0, "R6", "locked address gate", wr_gate[1], 0);
        do_write(3'd2, 8'h00);
        chk(pga_mute == 1'b0, "R5", "mute write in cal", pga_mute, 0);
        chk(cal_busy == 1'b1, "R3", "cal continues", cal_busy, 1);
      end
    end
    do_tick(123, -456, 123, -456, "R7");
    do_tick(-77, 88, -77, 88, "R8");

    repeat (3) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

endmodule